// File: doc/BRIEF.md
# Panel Power Sequence Controller

This block brings a display panel up and down by walking through two fixed scripts held in an internal constant table. Each script step is one of: a register write handed to an external register write framer, a timed wait counted in whole milliseconds, a change of the panel reset control line, or the end of the script. Register writes use a request/done handshake. The controller holds the request, address and data steady until the framer returns a one-cycle done pulse, and only then moves on.

The power-up script releases the panel reset line and clears every configuration register. It then ramps the panel supply and common-voltage settings in stages, with a wait after each stage. It loads the main configuration and the gamma table and finally switches the outputs on. The power-down script turns the supplies off in the opposite order and drives the reset line low again. Millisecond waits come from a prescaler on the system clock. The prescaler restarts at the beginning of every wait, so a wait never runs short.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, `panel_reset_n` is 0, `panel_ready` is 0, `wr_req` is 0 and `idle` is 1.
- R2: A power-up raises `panel_reset_n` before any register write. The first write request comes at least 1 ms after that.
- R3: The first power-up writes, in this order, are: address 0x01 = 0x001D; zero to 0x02, 0x03, 0x04; 0x05 = 0x40A3; zero to 0x06 through 0x0A in rising order; zero to 0x10 through 0x19 in rising order. A wait of at least 10 ms follows.
- R4: Next come 0x09 = 0x4055, 0x0A = 0x0000, a wait of at least 40 ms, 0x0A = 0x2000, and another wait of at least 40 ms.
- R5: Next come 0x01=0x401D, 0x02=0x0204, 0x03=0x0100, 0x04=0x1000, 0x05=0x5033, 0x06=0x0005, 0x07=0x001B, 0x08=0x0800. Then addresses 0x10..0x19 receive 0x0203, 0x0302, 0x0C08, 0x0C08, 0x0707, 0x0707, 0x0104, 0x0306, 0x0000, 0x0000, and a wait of at least 60 ms follows.
- R6: Power-up finishes with 0x09 = 0x0A55 and 0x0A = 0x111A, then a wait of at least 10 ms. `panel_ready` rises only after that wait, in the same cycle that `idle` returns to 1.
- R7: Power-down writes 0x09=0x0855, waits 20 ms, writes 0x09=0x0055, 0x05=0x4033, 0x0A=0x0000, waits 20 ms, writes 0x09=0x0000, waits 10 ms, then drives `panel_reset_n` to 0 and returns to idle.
- R8: A wait of N ms lasts at least N*MS_CYCLES clock cycles and at most a few cycles more. Consecutive writes with no wait between them are issued within 3 cycles of the previous done pulse.
- R9: A command is accepted only while `idle` is 1. A command pulse raised while a script is running changes neither the writes nor the final state. `wr_req` is never high while `idle` is 1.
- R10: `panel_ready` falls in the cycle after a power-down command is accepted, and `idle` drops in that same cycle.
- R11: `wr_req`, `wr_addr` and `wr_data` stay constant until `wr_done` is seen. A `wr_done` pulse outside a pending write has no effect.
- R12: If `pwr_on_cmd` and `pwr_off_cmd` are both high in an idle cycle, the power-down script runs (parameter `OFF_WINS` = 1, the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_cmd | input | 1 | Start the power-up script (sampled when idle) |
| pwr_off_cmd | input | 1 | Start the power-down script (sampled when idle) |
| wr_req | output | 1 | Register write request to the framer, held until done |
| wr_addr | output | 8 | Panel register address of the pending write |
| wr_data | output | 16 | Value of the pending write |
| wr_done | input | 1 | One-cycle completion pulse from the framer |
| panel_reset_n | output | 1 | Panel reset control line, low = held in reset |
| panel_ready | output | 1 | Panel fully powered and configured |
| idle | output | 1 | No script in progress |

## Verification
The bench logs every write handshake. It compares the full ordered address/data stream of both scripts against its own list. A table entry that is swapped, mistyped or skipped therefore appears as a wrong value at a known write index. Wait lengths are measured from the done pulse before a wait to the next request, reset edge or ready edge, with a short prescale. A prescaler that runs free instead of restarting, or a wait that is one millisecond short, falls below the lower bound. Commands are pulsed in the middle of both scripts and both commands are raised together from idle. A controller that restarts or switches script shows up as a broken write stream or a wrong final ready or reset level. The framer latency is varied, and a done pulse is sent while idle, to catch a request dropped early or a step advanced without a real handshake.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   localparam int REG_AW = 8;
   localparam int REG_DW = 16;

   // script layout: power-up occupies the low entries, power-down follows
   localparam int UP_FIRST   = 0;
   localparam int DOWN_FIRST = 51;
   localparam int SCRIPT_LEN = 61;
   localparam int IDX_W      = $clog2(SCRIPT_LEN);

   typedef enum logic [2:0] {
      OP_WRITE  = 3'd0,
      OP_WAIT   = 3'd1,
      OP_PIN_HI = 3'd2,
      OP_PIN_LO = 3'd3,
      OP_END    = 3'd4
   } step_op_e;

   typedef struct packed {
      step_op_e          op;
      logic [REG_AW-1:0] arg_a;
      logic [REG_DW-1:0] arg_d;
   } step_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_STEP  = 2'd1,
      SQ_WRITE = 2'd2,
      SQ_DELAY = 2'd3
   } seq_state_e;

   function automatic step_t mk_wr(input logic [REG_AW-1:0] a, input logic [REG_DW-1:0] d);
      step_t s;
      s.op    = OP_WRITE;
      s.arg_a = a;
      s.arg_d = d;
      return s;
   endfunction

   function automatic step_t mk_op(input step_op_e o, input logic [REG_DW-1:0] d);
      step_t s;
      s.op    = o;
      s.arg_a = '0;
      s.arg_d = d;
      return s;
   endfunction

endpackage

// File: rtl/pwrseq_script.sv
module pwrseq_script
   import pwrseq_pkg::*;
(
   input  logic [IDX_W-1:0] idx,
   output step_t            step
);

   // gamma table values, index 0..9
   function automatic logic [REG_DW-1:0] gamma_val(input int unsigned g);
      case (g)
         0:       return 16'h0203;
         1:       return 16'h0302;
         2, 3:    return 16'h0C08;
         4, 5:    return 16'h0707;
         6:       return 16'h0104;
         7:       return 16'h0306;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic step_t lookup(input int unsigned i);
      if (i >= 3 && i <= 5)
         return mk_wr(REG_AW'(i - 1), '0);
      if (i >= 7 && i <= 11)
         return mk_wr(REG_AW'(i - 1), '0);
      if (i >= 12 && i <= 21)
         return mk_wr(REG_AW'(8'h10 + (i - 12)), '0);
      if (i >= 36 && i <= 45)
         return mk_wr(REG_AW'(8'h10 + (i - 36)), gamma_val(i - 36));
      case (i)
         0:  return mk_op(OP_PIN_HI, '0);
         1:  return mk_op(OP_WAIT, 16'd1);
         2:  return mk_wr(8'h01, 16'h001D);
         6:  return mk_wr(8'h05, 16'h40A3);
         22: return mk_op(OP_WAIT, 16'd10);
         23: return mk_wr(8'h09, 16'h4055);
         24: return mk_wr(8'h0A, 16'h0000);
         25: return mk_op(OP_WAIT, 16'd40);
         26: return mk_wr(8'h0A, 16'h2000);
         27: return mk_op(OP_WAIT, 16'd40);
         28: return mk_wr(8'h01, 16'h401D);
         29: return mk_wr(8'h02, 16'h0204);
         30: return mk_wr(8'h03, 16'h0100);
         31: return mk_wr(8'h04, 16'h1000);
         32: return mk_wr(8'h05, 16'h5033);
         33: return mk_wr(8'h06, 16'h0005);
         34: return mk_wr(8'h07, 16'h001B);
         35: return mk_wr(8'h08, 16'h0800);
         46: return mk_op(OP_WAIT, 16'd60);
         47: return mk_wr(8'h09, 16'h0A55);
         48: return mk_wr(8'h0A, 16'h111A);
         49: return mk_op(OP_WAIT, 16'd10);
         50: return mk_op(OP_END, '0);
         51: return mk_wr(8'h09, 16'h0855);
         52: return mk_op(OP_WAIT, 16'd20);
         53: return mk_wr(8'h09, 16'h0055);
         54: return mk_wr(8'h05, 16'h4033);
         55: return mk_wr(8'h0A, 16'h0000);
         56: return mk_op(OP_WAIT, 16'd20);
         57: return mk_wr(8'h09, 16'h0000);
         58: return mk_op(OP_WAIT, 16'd10);
         59: return mk_op(OP_PIN_LO, '0);
         default: return mk_op(OP_END, '0);
      endcase
   endfunction

   always_comb step = lookup(int'(idx));

endmodule

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
   parameter int MS_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   if (MS_CYCLES < 1) begin : g_bad_div
      $error("pwrseq_tick: MS_CYCLES must be at least 1");
   end

   if (MS_CYCLES == 1) begin : g_every_cycle
      assign tick = 1'b1;
   end else begin : g_divider
      localparam int CW = $clog2(MS_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(MS_CYCLES - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (clr || cnt == LAST)
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == LAST);
   end

endmodule

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
   parameter int MS_CYCLES = 50000,
   parameter int WAIT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WAIT_W-1:0] len_ms,
   output logic              done
);

   if (WAIT_W < 1) begin : g_bad_w
      $error("pwrseq_delay: WAIT_W must be positive");
   end

   logic              tick;
   logic              busy;
   logic [WAIT_W-1:0] remain;

   // prescaler restarts with each wait, so every wait is whole milliseconds
   pwrseq_tick #(.MS_CYCLES(MS_CYCLES)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (start),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy   <= 1'b1;
            remain <= len_ms;
         end else if (busy && tick) begin
            if (remain <= WAIT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               remain <= remain - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
   import pwrseq_pkg::*;
#(
   parameter int MS_CYCLES = 50000,
   parameter int WAIT_W    = 8,
   parameter bit OFF_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_on_cmd,
   input  logic              pwr_off_cmd,
   output logic              wr_req,
   output logic [REG_AW-1:0] wr_addr,
   output logic [REG_DW-1:0] wr_data,
   input  logic              wr_done,
   output logic              panel_reset_n,
   output logic              panel_ready,
   output logic              idle
);

   localparam logic [IDX_W-1:0] UP_IDX   = IDX_W'(UP_FIRST);
   localparam logic [IDX_W-1:0] DOWN_IDX = IDX_W'(DOWN_FIRST);

   if (WAIT_W < 7 || WAIT_W > REG_DW) begin : g_bad_wait_w
      $error("pwrseq_ctrl: WAIT_W must hold 60 and fit in a step argument");
   end
   if (MS_CYCLES < 1) begin : g_bad_ms
      $error("pwrseq_ctrl: MS_CYCLES must be at least 1");
   end

   seq_state_e       state;
   logic [IDX_W-1:0] idx;
   logic             going_up;
   step_t            cur;
   logic             tmr_start;
   logic             tmr_done;
   logic             take_on;
   logic             take_off;

   // command arbitration when both arrive in the same idle cycle
   if (OFF_WINS) begin : g_off_first
      assign take_off = pwr_off_cmd;
      assign take_on  = pwr_on_cmd && !pwr_off_cmd;
   end else begin : g_on_first
      assign take_on  = pwr_on_cmd;
      assign take_off = pwr_off_cmd && !pwr_on_cmd;
   end

   pwrseq_script u_script (
      .idx (idx),
      .step(cur)
   );

   assign tmr_start = (state == SQ_STEP) && (cur.op == OP_WAIT);

   pwrseq_delay #(.MS_CYCLES(MS_CYCLES), .WAIT_W(WAIT_W)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .len_ms(cur.arg_d[WAIT_W-1:0]),
      .done  (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= SQ_IDLE;
         idx           <= '0;
         going_up      <= 1'b0;
         wr_req        <= 1'b0;
         wr_addr       <= '0;
         wr_data       <= '0;
         panel_reset_n <= 1'b0;
         panel_ready   <= 1'b0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (take_off) begin
                  state       <= SQ_STEP;
                  idx         <= DOWN_IDX;
                  going_up    <= 1'b0;
                  panel_ready <= 1'b0;
               end else if (take_on) begin
                  state       <= SQ_STEP;
                  idx         <= UP_IDX;
                  going_up    <= 1'b1;
                  panel_ready <= 1'b0;
               end
            end
            SQ_STEP: begin
               case (cur.op)
                  OP_WRITE: begin
                     wr_req  <= 1'b1;
                     wr_addr <= cur.arg_a;
                     wr_data <= cur.arg_d;
                     state   <= SQ_WRITE;
                  end
                  OP_WAIT: state <= SQ_DELAY;
                  OP_PIN_HI: begin
                     panel_reset_n <= 1'b1;
                     idx           <= idx + 1'b1;
                  end
                  OP_PIN_LO: begin
                     panel_reset_n <= 1'b0;
                     idx           <= idx + 1'b1;
                  end
                  default: begin
                     state       <= SQ_IDLE;
                     panel_ready <= going_up;
                  end
               endcase
            end
            SQ_WRITE: begin
               if (wr_done) begin
                  wr_req <= 1'b0;
                  idx    <= idx + 1'b1;
                  state  <= SQ_STEP;
               end
            end
            SQ_DELAY: begin
               if (tmr_done) begin
                  idx   <= idx + 1'b1;
                  state <= SQ_STEP;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign idle = (state == SQ_IDLE);

endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk
   import pwrseq_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_req,
   input logic [REG_AW-1:0] wr_addr,
   input logic [REG_DW-1:0] wr_data,
   input logic              wr_done,
   input logic              panel_reset_n,
   input logic              panel_ready,
   input logic              idle
);

   // R11: a pending write holds its request and payload until done
   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

   // R9: no write is requested while idle
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !wr_req);

   // R6: ready rises only when the script has finished
   assert_ready_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(panel_ready) |-> idle);

   // R10: ready falls only because a script has started
   assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(panel_ready) |-> !idle);

   // R6: a ready panel is out of reset
   assert_ready_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      panel_ready |-> panel_reset_n);

   // R11: the request drops only on a done pulse
   assert_req_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_req) |-> $past(wr_done));

endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_req       (wr_req),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .wr_done      (wr_done),
   .panel_reset_n(panel_reset_n),
   .panel_ready  (panel_ready),
   .idle         (idle)
);

// File: tb/pwrseq_ctrl_test.sv
module pwrseq_ctrl_test;

   localparam int DIV  = 4;
   localparam int SLOP = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        on_cmd = 1'b0;
   logic        off_cmd = 1'b0;
   logic        wr_done = 1'b0;
   logic        wr_req;
   logic [7:0]  wr_addr;
   logic [15:0] wr_data;
   logic        pin;
   logic        ready;
   logic        idle;

   pwrseq_ctrl #(.MS_CYCLES(DIV), .WAIT_W(8), .OFF_WINS(1'b1)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .pwr_on_cmd   (on_cmd),
      .pwr_off_cmd  (off_cmd),
      .wr_req       (wr_req),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .wr_done      (wr_done),
      .panel_reset_n(pin),
      .panel_ready  (ready),
      .idle         (idle)
   );

   always #10 clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // write log
   int          nlog = 0;
   logic [7:0]  la [0:63];
   logic [15:0] ld [0:63];
   int          lreq [0:63];
   int          ldone [0:63];
   int          rel_cyc = 0, fall_cyc = 0, rdy_cyc = 0;
   int          lat = 1;
   int          lc = 0;
   bit          poke = 1'b0;
   bit          prev_req = 1'b0, prev_pin = 1'b0, prev_rdy = 1'b0;

   // expected streams
   logic [7:0]  ua [0:63];
   logic [15:0] ud [0:63];
   int          nu = 0;
   logic [7:0]  da [0:7];
   logic [15:0] dd [0:7];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   task automatic push(input int a, input int d);
      ua[nu] = 8'(a);
      ud[nu] = 16'(d);
      nu++;
   endtask

   task automatic build_expected();
      int g [0:9] = '{'h0203, 'h0302, 'h0C08, 'h0C08, 'h0707,
                      'h0707, 'h0104, 'h0306, 0, 0};
      int c [0:7] = '{'h401D, 'h0204, 'h0100, 'h1000, 'h5033,
                      'h0005, 'h001B, 'h0800};
      nu = 0;
      push(1, 'h001D);
      for (int a = 2; a <= 4; a++) push(a, 0);
      push(5, 'h40A3);
      for (int a = 6; a <= 10; a++) push(a, 0);
      for (int a = 16; a <= 25; a++) push(a, 0);
      push(9, 'h4055);
      push(10, 0);
      push(10, 'h2000);
      for (int k = 0; k < 8; k++) push(k + 1, c[k]);
      for (int k = 0; k < 10; k++) push(16 + k, g[k]);
      push(9, 'h0A55);
      push(10, 'h111A);
      da[0] = 8'h09; dd[0] = 16'h0855;
      da[1] = 8'h09; dd[1] = 16'h0055;
      da[2] = 8'h05; dd[2] = 16'h4033;
      da[3] = 8'h0A; dd[3] = 16'h0000;
      da[4] = 8'h09; dd[4] = 16'h0000;
   endtask

   // cycle counter
   initial forever begin
      @(posedge clk);
      cyc++;
   end

   // framer model and monitor, all at the falling edge
   initial forever begin
      @(negedge clk);
      if (wr_req && !prev_req && nlog < 64) lreq[nlog] = cyc;
      if (wr_done) begin
         wr_done = 1'b0;
      end else if (wr_req) begin
         lc++;
         if (lc >= lat) begin
            wr_done = 1'b1;
            if (nlog < 64) begin
               la[nlog] = wr_addr;
               ld[nlog] = wr_data;
               ldone[nlog] = cyc;
            end
            nlog++;
            lc = 0;
         end
      end else if (poke) begin
         wr_done = 1'b1;
         poke = 1'b0;
      end
      if (pin && !prev_pin) rel_cyc = cyc;
      if (!pin && prev_pin) fall_cyc = cyc;
      if (ready && !prev_rdy) rdy_cyc = cyc;
      prev_req = wr_req;
      prev_pin = pin;
      prev_rdy = ready;
   end

   task automatic wait_idle(input string req);
      int n = 0;
      while (!idle && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check(idle, req, "script finished before timeout", int'(idle), 1);
   endtask

   task automatic gap(input string req, input string what, input int got, input int ms);
      check(got >= ms * DIV && got <= ms * DIV + SLOP, req, what, got, ms * DIV);
   endtask

   task automatic start(input bit want_on, input bit want_off, input int latency);
      nlog = 0;
      lc = 0;
      lat = latency;
      rel_cyc = 0;
      fall_cyc = 0;
      rdy_cyc = 0;
      @(negedge clk);
      on_cmd = want_on;
      off_cmd = want_off;
      @(negedge clk);
      on_cmd = 1'b0;
      off_cmd = 1'b0;
   endtask

   task automatic disturb();
      repeat (40) @(negedge clk);
      on_cmd = 1'b1;
      off_cmd = 1'b1;
      @(negedge clk);
      on_cmd = 1'b0;
      off_cmd = 1'b0;
   endtask

   task automatic run_up(input int latency, input bit noisy);
      start(1'b1, 1'b0, latency);
      check(!idle, "R9", "idle drops after accepted power-on", int'(idle), 0);
      if (noisy) disturb();
      wait_idle("R2");
      check(nlog == nu, "R3", "power-up write count", nlog, nu);
      for (int i = 0; i < nu && i < nlog; i++) begin
         string r;
         r = (i < 20) ? "R3" : (i < 23) ? "R4" : (i < 41) ? "R5" : "R6";
         check(la[i] == ua[i], r, $sformatf("write %0d address", i), int'(la[i]), int'(ua[i]));
         check(ld[i] == ud[i], r, $sformatf("write %0d data", i), int'(ld[i]), int'(ud[i]));
         check(ldone[i] - lreq[i] == latency - 1, "R11",
               $sformatf("write %0d held until done", i), ldone[i] - lreq[i], latency - 1);
      end
      if (nlog == nu) begin
         check(rel_cyc > 0 && rel_cyc < lreq[0], "R2", "reset line released before first write",
               rel_cyc, lreq[0]);
         gap("R2", "release to first write", lreq[0] - rel_cyc, 1);
         gap("R3", "wait after clearing batch", lreq[20] - ldone[19], 10);
         gap("R4", "first supply wait", lreq[22] - ldone[21], 40);
         gap("R4", "second supply wait", lreq[23] - ldone[22], 40);
         gap("R5", "wait after gamma", lreq[41] - ldone[40], 60);
         gap("R6", "final wait before ready", rdy_cyc - ldone[42], 10);
         for (int i = 0; i + 1 < nu; i++) begin
            if (i != 19 && i != 21 && i != 22 && i != 40)
               check(lreq[i+1] - ldone[i] >= 1 && lreq[i+1] - ldone[i] <= 3, "R8",
                     $sformatf("back-to-back gap after write %0d", i), lreq[i+1] - ldone[i], 2);
         end
      end
      check(ready == 1'b1, "R6", "ready after power-up", int'(ready), 1);
      check(pin == 1'b1, "R2", "reset line high after power-up", int'(pin), 1);
   endtask

   task automatic run_down(input int latency, input bit noisy, input bit both);
      start(both, 1'b1, latency);
      check(!ready, "R10", "ready drops right after power-down accepted", int'(ready), 0);
      check(!idle, "R10", "idle drops right after power-down accepted", int'(idle), 0);
      if (noisy) disturb();
      wait_idle("R7");
      check(nlog == 5, both ? "R12" : "R7", "power-down write count", nlog, 5);
      for (int i = 0; i < 5 && i < nlog; i++) begin
         check(la[i] == da[i], both ? "R12" : "R7", $sformatf("down write %0d address", i),
               int'(la[i]), int'(da[i]));
         check(ld[i] == dd[i], "R7", $sformatf("down write %0d data", i), int'(ld[i]), int'(dd[i]));
      end
      if (nlog == 5) begin
         gap("R7", "first off wait", lreq[1] - ldone[0], 20);
         gap("R7", "second off wait", lreq[4] - ldone[3], 20);
         gap("R7", "last off wait before reset", fall_cyc - ldone[4], 10);
      end
      check(pin == 1'b0, "R7", "reset line low after power-down", int'(pin), 0);
      check(ready == 1'b0, "R7", "ready low after power-down", int'(ready), 0);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "WDOG", "run finished in time", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      build_expected();
      repeat (3) @(negedge clk);
      // R1 reset state
      check(pin == 1'b0, "R1", "reset line low in reset", int'(pin), 0);
      check(ready == 1'b0, "R1", "ready low in reset", int'(ready), 0);
      check(wr_req == 1'b0, "R1", "no request in reset", int'(wr_req), 0);
      check(idle == 1'b1, "R1", "idle in reset", int'(idle), 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R11: stray done pulse while idle
      poke = 1'b1;
      repeat (4) @(negedge clk);
      check(idle && !wr_req && nlog == 0, "R11", "stray done while idle ignored",
            int'(idle), 1);

      run_up(1, 1'b1);
      run_down(5, 1'b1, 1'b0);
      run_up(3, 1'b0);
      run_down(1, 1'b0, 1'b1);
      run_up(2, 1'b0);
      run_down(2, 1'b1, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule